// File: doc/BRIEF.md
# DSP Core Interrupt Controller

This block gathers eight maskable interrupt sources for a small DSP core, picks one by fixed priority and dispatches it. It produces a one-cycle taken strobe together with the source index and the start word of that source's four-word slot in the vector table. Three of the sources are active-low external lines. Each line can be set to edge or level sensitivity. Two sources are software-only. The other three are internal single-cycle requests, such as timer or serial-port events.

Software reaches the pending latches through a 16-bit write-only force/clear word. The low half cancels and the high half raises. A small control word selects the sensitivity of each external line and enables nesting. The core supplies its mask register and a pulse that marks the return from a service routine. The block keeps track of the active service routines, so that it can tell when a new dispatch is allowed.

Top module: `dsp_int_ctrl`

## Requirements
- R1: While `rst_ni` is low, `irq_take_o` is 0, every pending latch is empty, all external lines are in level mode and nesting is off.
- R2: A write with `fc_wdata_i[8+k]` set raises the pending latch of source k. If source k is unmasked and dispatch is allowed, it is taken in the cycle right after the write.
- R3: A write with `fc_wdata_i[k]` set (k in 0..7) empties the pending latch of source k. When the clear bit and the force bit for one source are written together, the clear wins.
- R4: Sources 3 and 4 are the software interrupts. They have no hardware input and are raised only by force bits 11 and 12.
- R5: When `ctl_wdata_i[k]` is 1 for external line k (k in 0..2), the line is in edge mode. A falling edge is latched. It is dispatched two cycles after the line drops, and it stays pending after the line goes high again.
- R6: When `ctl_wdata_i[k]` is 0, line k is in level mode and has no latch. The line requests while its synchronized level is low: dispatch comes two cycles after the drop. A low pulse that ends while the line is masked is lost, and a line still held low is taken again after the return.
- R7: Among the eligible sources the lowest index wins. `irq_vec_o` equals the index times 4, and `irq_id_o` equals the index.
- R8: A source whose `imask_i` bit is 0 is never dispatched. Its pending latch is kept, and the source is dispatched in the cycle its mask bit becomes 1.
- R9: While nesting is off (`ctl_wdata_i[4]` = 0), no dispatch happens while a service routine is active. After `isr_ret_i`, dispatch resumes on the next cycle.
- R10: While nesting is on, only a source with strictly lower index than every active routine may preempt. `isr_ret_i` ends the most recently taken routine.
- R11: Dispatching a source empties its pending latch, and `irq_take_o` lasts one cycle for each dispatch.
- R12: An internal request `int_req_i[j]` that is high for one cycle raises the pending latch of source 5+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_irq_ni | input | 3 | External request lines, active low, asynchronous |
| int_req_i | input | 3 | Internal request pulses for sources 5..7 |
| fc_we_i | input | 1 | Write strobe of the force/clear word |
| fc_wdata_i | input | 16 | Bits 0..7 clear, bits 8..15 force sources 0..7 |
| ctl_we_i | input | 1 | Write strobe of the control word |
| ctl_wdata_i | input | 5 | Bits 0..2 edge(1)/level(0) of lines 0..2, bit 4 nesting enable |
| imask_i | input | 8 | Per-source enable from the core mask register |
| isr_ret_i | input | 1 | Return-from-service pulse |
| irq_take_o | output | 1 | Interrupt-taken strobe |
| irq_id_o | output | 3 | Index of the taken source |
| irq_vec_o | output | 5 | Vector table word address of the taken source |

## Verification
The software sources are raised with single force bits, to separate the vector arithmetic from any input timing. Several forced sources are then released at once, which shows the fixed priority order and the serial dispatch between returns. The external lines are driven as short low pulses under a mask and as long held lows. This separates edge latching from level sampling, and the lost pulse from the repeated take. Overlapping forces with nesting on and off show the preemption rule: only a strictly higher source gets through, and the lower ones wait.

// File: rtl/dsp_int_pkg.sv
package dsp_int_pkg;
  localparam int N_SRC    = 8;
  localparam int N_EXT    = 3;
  localparam int SW_LO    = 3;
  localparam int SW_HI    = 4;
  localparam int INT_BASE = 5;
  localparam int N_INT    = N_SRC - INT_BASE;
  localparam int SLOT_W   = 2;                 // log2 of words per vector slot
  localparam int ID_W     = $clog2(N_SRC);
  localparam int VEC_W    = ID_W + SLOT_W;
  localparam int FC_W     = 2 * N_SRC;
  localparam int CTL_NEST = 4;
  localparam int CTL_W    = CTL_NEST + 1;

  typedef enum logic [1:0] {SRC_EXT, SRC_SW, SRC_INT} src_kind_e;

  function automatic src_kind_e src_kind(input int idx);
    if (idx < N_EXT) return SRC_EXT;
    if (idx >= SW_LO && idx <= SW_HI) return SRC_SW;
    return SRC_INT;
  endfunction
endpackage

// File: rtl/int_sync.sv
module int_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] line_ni,
  output logic [W-1:0] low_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '1;
      s2_q   <= '1;
      prev_q <= '1;
    end else begin
      s1_q   <= line_ni;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign low_o  = ~s2_q;
  assign fall_o = prev_q & ~s2_q;
endmodule

// File: rtl/int_pending.sv
module int_pending
  import dsp_int_pkg::*;
#(
  parameter int NSrc = N_SRC,
  parameter int NExt = N_EXT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NExt-1:0]   fall_i,
  input  logic [NExt-1:0]   low_i,
  input  logic [NExt-1:0]   sense_i,
  input  logic [N_INT-1:0]  int_req_i,
  input  logic              fc_we_i,
  input  logic [2*NSrc-1:0] fc_wdata_i,
  input  logic [NSrc-1:0]   take_oh_i,
  output logic [NSrc-1:0]   req_o
);
  logic [NSrc-1:0] pend_q, set, now, clr, frc;

  assign clr = fc_we_i ? fc_wdata_i[NSrc-1:0]      : '0;
  assign frc = fc_we_i ? fc_wdata_i[2*NSrc-1:NSrc] : '0;

  for (genvar i = 0; i < NSrc; i++) begin : g_src
    if (src_kind(i) == SRC_EXT) begin : g_ext
      // edge mode: latch the fall, and let it request in the same cycle
      assign set[i] = (sense_i[i] & fall_i[i]) | frc[i];
      assign now[i] = sense_i[i] ? fall_i[i] : low_i[i];
    end else if (src_kind(i) == SRC_SW) begin : g_sw
      assign set[i] = frc[i];
      assign now[i] = 1'b0;
    end else begin : g_int
      assign set[i] = int_req_i[i-INT_BASE] | frc[i];
      assign now[i] = 1'b0;
    end

    a_r3_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr[i] |=> !pend_q[i]);
    a_r2_force_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frc[i] && !clr[i] && !take_oh_i[i]) |=> pend_q[i]);
    a_r11_take_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_oh_i[i] && !set[i]) |=> !pend_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q | set) & ~take_oh_i & ~clr;
  end

  assign req_o = pend_q | now;
endmodule

// File: rtl/int_arb.sv
module int_arb
  import dsp_int_pkg::*;
#(
  parameter int NSrc = N_SRC
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NSrc-1:0]          req_i,
  input  logic [NSrc-1:0]          imask_i,
  input  logic                     nest_en_i,
  input  logic                     isr_ret_i,
  output logic                     take_o,
  output logic [$clog2(NSrc)-1:0]  take_id_o,
  output logic [NSrc-1:0]          take_oh_o
);
  localparam int IdW = $clog2(NSrc);

  logic [NSrc-1:0] act_q, act_d, elig, ret_oh;
  logic [IdW-1:0]  cand_id, low_act_id;
  logic            cand_vld, act_vld;

  assign elig    = req_i & imask_i;
  assign act_vld = |act_q;
  assign ret_oh  = act_q & (~act_q + NSrc'(1));

  always_comb begin
    cand_vld   = 1'b0;
    cand_id    = '0;
    low_act_id = '0;
    for (int i = NSrc - 1; i >= 0; i--) begin
      if (elig[i]) begin
        cand_vld = 1'b1;
        cand_id  = IdW'(i);
      end
      if (act_q[i]) low_act_id = IdW'(i);
    end
  end

  assign take_o    = cand_vld && (!act_vld || (nest_en_i && cand_id < low_act_id));
  assign take_id_o = cand_id;
  assign take_oh_o = take_o ? (NSrc'(1) << cand_id) : '0;
  assign act_d     = (act_q & ~(isr_ret_i ? ret_oh : '0)) | take_oh_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_d;
  end

  a_r9_hold_no_nest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nest_en_i && act_vld) |-> !take_o);
  a_r10_preempt_higher: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && act_vld) |-> (nest_en_i && take_id_o < low_act_id));
  a_r11_active_onehot_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> act_q[$past(take_id_o)]);
endmodule

// File: rtl/dsp_int_ctrl.sv
module dsp_int_ctrl
  import dsp_int_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EXT-1:0]  ext_irq_ni,
  input  logic [N_INT-1:0]  int_req_i,
  input  logic              fc_we_i,
  input  logic [FC_W-1:0]   fc_wdata_i,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic [N_SRC-1:0]  imask_i,
  input  logic              isr_ret_i,
  output logic              irq_take_o,
  output logic [ID_W-1:0]   irq_id_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  logic [N_EXT-1:0] sense_q, low, fall;
  logic             nest_q;
  logic [N_SRC-1:0] req, take_oh;
  logic             ctl_unused;

  assign ctl_unused = ^ctl_wdata_i[CTL_NEST-1:N_EXT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
      nest_q  <= 1'b0;
    end else if (ctl_we_i) begin
      sense_q <= ctl_wdata_i[N_EXT-1:0];
      nest_q  <= ctl_wdata_i[CTL_NEST];
    end
  end

  int_sync #(.W(N_EXT)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_ni (ext_irq_ni),
    .low_o   (low),
    .fall_o  (fall)
  );

  int_pending #(.NSrc(N_SRC), .NExt(N_EXT)) i_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_i     (fall),
    .low_i      (low),
    .sense_i    (sense_q),
    .int_req_i  (int_req_i),
    .fc_we_i    (fc_we_i),
    .fc_wdata_i (fc_wdata_i),
    .take_oh_i  (take_oh),
    .req_o      (req)
  );

  int_arb #(.NSrc(N_SRC)) i_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .imask_i   (imask_i),
    .nest_en_i (nest_q),
    .isr_ret_i (isr_ret_i),
    .take_o    (irq_take_o),
    .take_id_o (irq_id_o),
    .take_oh_o (take_oh)
  );

  assign irq_vec_o = {irq_id_o, {SLOT_W{1'b0}}};

  a_r8_masked_never_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> imask_i[irq_id_o]);
  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !irq_take_o);
endmodule

// File: tb/test_dsp_int_ctrl.sv
`timescale 1ns/1ps
module test_dsp_int_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  ext_irq_ni = 3'b111;
  logic [2:0]  int_req_i = '0;
  logic        fc_we_i = 1'b0;
  logic [15:0] fc_wdata_i = '0;
  logic        ctl_we_i = 1'b0;
  logic [4:0]  ctl_wdata_i = '0;
  logic [7:0]  imask_i = 8'hff;
  logic        isr_ret_i = 1'b0;
  logic        irq_take_o;
  logic [2:0]  irq_id_o;
  logic [4:0]  irq_vec_o;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  always #4 clk_i = ~clk_i;

  dsp_int_ctrl i_dsp_int_ctrl (
    .clk_i, .rst_ni, .ext_irq_ni, .int_req_i, .fc_we_i, .fc_wdata_i,
    .ctl_we_i, .ctl_wdata_i, .imask_i, .isr_ret_i, .irq_take_o, .irq_id_o, .irq_vec_o
  );

  // behavioural reference model
  bit m_s1[3], m_s2[3], m_prev[3], m_sense[3];
  bit m_nest;
  bit m_pend[8], m_act[8], m_req[8];
  int m_cand, m_low;
  bit m_take;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 3; i++) begin
        m_s1[i] = 1; m_s2[i] = 1; m_prev[i] = 1; m_sense[i] = 0;
      end
      for (int i = 0; i < 8; i++) begin m_pend[i] = 0; m_act[i] = 0; end
      m_nest = 0;
      n_checks++;
      if (irq_take_o !== 1'b0) begin
        n_fail++;
        $display("FAIL R1 reset take=%0b expected 0", irq_take_o);
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        if (i < 3) m_req[i] = m_pend[i] || (m_sense[i] ? (m_prev[i] && !m_s2[i]) : !m_s2[i]);
        else       m_req[i] = m_pend[i];
      end
      m_cand = -1;
      for (int i = 7; i >= 0; i--) if (m_req[i] && imask_i[i]) m_cand = i;
      m_low = 8;
      for (int i = 7; i >= 0; i--) if (m_act[i]) m_low = i;
      m_take = (m_cand >= 0) && (m_low == 8 || (m_nest && m_cand < m_low));
      n_checks++;
      if (irq_take_o !== m_take || (m_take && (irq_vec_o !== 5'(m_cand * 4) || irq_id_o !== 3'(m_cand)))) begin
        n_fail++;
        $display("FAIL %s model: take=%0b vec=%0d id=%0d expected take=%0b vec=%0d",
                 cur_req, irq_take_o, irq_vec_o, irq_id_o, m_take, m_cand * 4);
      end
      // next state
      for (int i = 0; i < 8; i++) begin
        bit set;
        set = 0;
        if (i < 3) set = m_sense[i] && m_prev[i] && !m_s2[i];
        else if (i >= 5) set = int_req_i[i-5];
        if (fc_we_i && fc_wdata_i[8+i]) set = 1;
        m_pend[i] = (m_pend[i] || set) && !(m_take && m_cand == i);
        if (fc_we_i && fc_wdata_i[i]) m_pend[i] = 0;
      end
      if (isr_ret_i && m_low < 8) m_act[m_low] = 0;
      if (m_take) m_act[m_cand] = 1;
      if (ctl_we_i) begin
        for (int i = 0; i < 3; i++) m_sense[i] = ctl_wdata_i[i];
        m_nest = ctl_wdata_i[4];
      end
      for (int i = 0; i < 3; i++) begin
        m_prev[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = ext_irq_ni[i];
      end
    end
  end

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic fc_write(input logic [15:0] d);
    step(); fc_we_i = 1'b1; fc_wdata_i = d;
    step(); fc_we_i = 1'b0; fc_wdata_i = '0;
  endtask

  task automatic ctl_write(input logic [4:0] d);
    step(); ctl_we_i = 1'b1; ctl_wdata_i = d;
    step(); ctl_we_i = 1'b0;
  endtask

  task automatic isr_ret();
    step(); isr_ret_i = 1'b1;
    step(); isr_ret_i = 1'b0;
  endtask

  task automatic expect_neg(input string req, input bit exp_take, input int exp_vec);
    @(negedge clk_i);
    n_checks++;
    if (irq_take_o !== exp_take || (exp_take && irq_vec_o !== 5'(exp_vec))) begin
      n_fail++;
      $display("FAIL %s take=%0b vec=%0d expected take=%0b vec=%0d",
               req, irq_take_o, irq_vec_o, exp_take, exp_vec);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    cur_req = "R4";  // software sources via force bits 11 and 12
    fc_write(16'h0800); expect_neg("R4", 1, 12);
    isr_ret();
    cur_req = "R2";
    fc_write(16'h1000); expect_neg("R2", 1, 16);
    isr_ret(); expect_neg("R11", 0, 0);

    cur_req = "R3";
    step(); imask_i = 8'h00;
    fc_write(16'h4040);
    step(); imask_i = 8'hff; expect_neg("R3", 0, 0);
    step(); imask_i = 8'h00;
    fc_write(16'h8000); fc_write(16'h0080);
    step(); imask_i = 8'hff; expect_neg("R3", 0, 0);

    cur_req = "R8";
    step(); imask_i = 8'h00;
    fc_write(16'h2000); step(); step(); expect_neg("R8", 0, 0);
    step(); imask_i = 8'hff; expect_neg("R8", 1, 20);
    isr_ret();

    cur_req = "R7";
    step(); imask_i = 8'h00;
    fc_write(16'hc400);
    step(); imask_i = 8'hff; expect_neg("R7", 1, 8);
    cur_req = "R9";
    isr_ret(); expect_neg("R7", 1, 24);
    isr_ret(); expect_neg("R7", 1, 28);
    fc_write(16'h0100); expect_neg("R9", 0, 0);
    step(); expect_neg("R9", 0, 0);
    isr_ret(); expect_neg("R9", 1, 0);
    isr_ret();

    cur_req = "R5";
    ctl_write(5'b00001);
    step(); ext_irq_ni = 3'b110;
    step(); step(); expect_neg("R5", 1, 0);
    step(); ext_irq_ni = 3'b111;
    isr_ret(); expect_neg("R5", 0, 0);
    @(posedge clk_i); #1; imask_i = 8'h00; ext_irq_ni = 3'b110;
    step(); ext_irq_ni = 3'b111;
    repeat (4) step();
    step(); imask_i = 8'hff; expect_neg("R5", 1, 0);
    isr_ret();

    cur_req = "R6";
    @(posedge clk_i); #1; imask_i = 8'h00; ext_irq_ni = 3'b101;
    step(); ext_irq_ni = 3'b111;
    repeat (4) step();
    step(); imask_i = 8'hff; expect_neg("R6", 0, 0);
    step(); ext_irq_ni = 3'b101;
    step(); step(); expect_neg("R6", 1, 4);
    isr_ret(); expect_neg("R6", 1, 4);
    step(); ext_irq_ni = 3'b111;
    repeat (3) step();
    isr_ret(); expect_neg("R6", 0, 0);

    cur_req = "R10";
    ctl_write(5'b10001);
    fc_write(16'h4000); expect_neg("R10", 1, 24);
    fc_write(16'h8000); expect_neg("R10", 0, 0);
    fc_write(16'h0800); expect_neg("R10", 1, 12);
    isr_ret(); expect_neg("R10", 0, 0);
    isr_ret(); expect_neg("R10", 1, 28);
    isr_ret();

    cur_req = "R11";
    fc_write(16'h2000); expect_neg("R11", 1, 20);
    step(); expect_neg("R11", 0, 0);
    isr_ret(); expect_neg("R11", 0, 0);

    cur_req = "R12";
    step(); int_req_i = 3'b010;
    step(); int_req_i = 3'b000; expect_neg("R12", 1, 24);
    isr_ret(); expect_neg("R12", 0, 0);

    repeat (4) step();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule